// File: doc/BRIEF.md
# Add/AND Execution Unit with Condition Flags

This unit executes two data-processing operations of a 32-bit processor pipeline: addition and bitwise AND. It receives the decoded instruction word, both operands (the second already through the barrel shifter, with that shifter's carry-out), the current and saved program status words and the result of condition evaluation. One clock later it presents the result, a register write enable, the next status word and a set of indicators. These say whether the status word was restored from the saved copy, whether that restore is unpredictable, and whether the word was not an operation this unit may execute.

The flag rules differ per operation. Addition derives carry and overflow from the arithmetic. AND takes carry from the shifter and keeps overflow. A flag-setting operation that targets register 15 replaces the whole status word with the saved copy instead of updating flags. The shifter, the condition check and the register file sit outside the unit.

Top module: `dp_alu_flags`

## Requirements
- R1: A word is accepted only when bits[27:26]=00 and bits[24:21] are 0100 (add) or 0000 (AND). Any other word raises `not_exec` one cycle later with `rd_we`=0 and `psr_we`=0.
- R2: When bit[25]=0 and bits 7 and 4 are both 1, the word is not executed: `not_exec`=1, `rd_we`=0, `psr_we`=0. With bit[25]=1 the same bit 7/4 values execute normally.
- R3: When `cond_ok`=0, neither the register nor the status word is written (`rd_we`=0, `psr_we`=0, `psr_next` equals the input `cur_psr`).
- R4: Add with bit[20]=1 and a destination other than 15 gives `res`=a+b mod 2^32. Bit 31 of `psr_next` is N=res[31], bit 30 is Z=(res==0), bit 29 is C=unsigned carry-out, bit 28 is V=signed overflow. Bits 27:0 are kept from `cur_psr`.
- R5: AND with bit[20]=1 and a destination other than 15 gives `res`=a&b, N and Z from the result and C=`shift_co`. V (bit 28) is kept from `cur_psr`.
- R6: With bit[20]=0 the status word is not written (`psr_we`=0, `psr_next`=`cur_psr`). The result is still written when the operation executes.
- R7: With bit[20]=1 and destination bits[15:12]=15, `psr_next` equals `saved_psr` and `psr_restore`=1 with `psr_we`=1. No flag update takes place.
- R8: `unpred`=1 exactly when a restore happens while `cur_psr[4:0]` is 10000 or 11111.
- R9: All outputs change one cycle after a valid input. A cycle without `in_valid` leaves `out_valid`, `rd_we`, `psr_we`, `not_exec` and `unpred` at 0 in the next cycle.
- R10: While `rst_n`=0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand after shifting |
| shift_co | input | 1 | Carry-out of the shifter |
| cond_ok | input | 1 | Condition evaluated as passed |
| cur_psr | input | 32 | Current status word, NZCV at bits 31:28, mode at 4:0 |
| saved_psr | input | 32 | Saved status word of the current mode |
| out_valid | output | 1 | Outputs below belong to the previous valid input |
| res | output | 32 | Result (0 when not executed) |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 4 | Destination register index |
| psr_next | output | 32 | Next status word |
| psr_we | output | 1 | Status word write enable |
| psr_restore | output | 1 | Status word restored from the saved copy |
| unpred | output | 1 | Restore attempted in a mode without a saved copy |
| not_exec | output | 1 | Word is not an add/AND this unit executes |

## Verification
Both operations are swept over every pair from the operand set {0, 1, 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF}. Each pair is run with both shifter carry values, both S settings and the condition both passing and failing. These pairs separate carry without overflow (0xFFFFFFFF+1), overflow without carry (0x7FFFFFFF+1) and both together (0x80000000+0x80000000), and they give a zero result in both operations. Random operand pairs cover the ordinary arithmetic. Directed words cover the register-15 restore in user, system and a privileged mode, the bit 7/4 exclusion against the immediate form, foreign opcodes and idle cycles.

// File: rtl/dp_alu_flags.sv
module dp_alu_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [31:0]  instr,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         shift_co,
  input  logic         cond_ok,
  input  logic [31:0]  cur_psr,
  input  logic [31:0]  saved_psr,
  output logic         out_valid,
  output logic [W-1:0] res,
  output logic         rd_we,
  output logic [3:0]   rd_idx,
  output logic [31:0]  psr_next,
  output logic         psr_we,
  output logic         psr_restore,
  output logic         unpred,
  output logic         not_exec
);
  localparam logic [3:0] OP_ADD = 4'b0100;
  localparam logic [3:0] OP_AND = 4'b0000;
  localparam logic [4:0] M_USR  = 5'b10000;
  localparam logic [4:0] M_SYS  = 5'b11111;

  wire [3:0] opc     = instr[24:21];
  wire       s_bit   = instr[20];
  wire [3:0] dst     = instr[15:12];
  wire       is_add  = opc == OP_ADD;
  wire       other_x = !instr[25] && instr[7] && instr[4];
  wire       dec_ok  = instr[27:26] == 2'b00 && (is_add || opc == OP_AND) && !other_x;
  wire       exec    = in_valid && dec_ok && cond_ok;

  wire [W:0]   sum  = {1'b0, op_a} + {1'b0, op_b};
  wire [W-1:0] val  = is_add ? sum[W-1:0] : (op_a & op_b);
  wire         c_n  = is_add ? sum[W] : shift_co;
  wire         v_n  = is_add ? (op_a[W-1] == op_b[W-1]) && (val[W-1] != op_a[W-1]) : cur_psr[28];
  wire         flg  = exec && s_bit;
  wire         rst_psr = flg && dst == 4'd15;
  wire [31:0]  upd  = {val[W-1], val == '0, c_n, v_n, cur_psr[27:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      res         <= '0;
      rd_we       <= 1'b0;
      rd_idx      <= '0;
      psr_next    <= '0;
      psr_we      <= 1'b0;
      psr_restore <= 1'b0;
      unpred      <= 1'b0;
      not_exec    <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      res         <= exec ? val : '0;
      rd_we       <= exec;
      rd_idx      <= dst;
      psr_next    <= rst_psr ? saved_psr : (flg ? upd : cur_psr);
      psr_we      <= flg;
      psr_restore <= rst_psr;
      unpred      <= rst_psr && (cur_psr[4:0] == M_USR || cur_psr[4:0] == M_SYS);
      not_exec    <= in_valid && !dec_ok;
    end
  end
endmodule

module dp_alu_flags_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [31:0]  instr,
  input logic         cond_ok,
  input logic [31:0]  cur_psr,
  input logic [31:0]  saved_psr,
  input logic         out_valid,
  input logic [W-1:0] res,
  input logic         rd_we,
  input logic [31:0]  psr_next,
  input logic         psr_we,
  input logic         psr_restore,
  input logic         unpred,
  input logic         not_exec
);
  assert_nowrite_on_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cond_ok) |=> (!rd_we && !psr_we));
  assert_not_exec_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    not_exec |-> (!rd_we && !psr_we));
  assert_s_clear_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !instr[20]) |=> (!psr_we && psr_next == $past(cur_psr)));
  assert_nz_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_we && !psr_restore) |-> (psr_next[31] == res[W-1] && psr_next[30] == (res == '0)));
  assert_and_keeps_v_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[24:21] == 4'b0000 && !(instr[20] && instr[15:12] == 4'd15))
      |=> psr_next[28] == $past(cur_psr[28]));
  assert_restore_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    psr_restore |-> (psr_we && psr_next == $past(saved_psr)));
  assert_unpred_only_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unpred |-> psr_restore);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!rd_we && !psr_we && !not_exec && !unpred));
endmodule

bind dp_alu_flags dp_alu_flags_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .cond_ok(cond_ok),
  .cur_psr(cur_psr), .saved_psr(saved_psr), .out_valid(out_valid), .res(res),
  .rd_we(rd_we), .psr_next(psr_next), .psr_we(psr_we), .psr_restore(psr_restore),
  .unpred(unpred), .not_exec(not_exec)
);

// File: tb/dp_alu_flags_tb.sv
module dp_alu_flags_tb;
  logic        clk = 0, rst_n = 0, in_valid = 0, shift_co = 0, cond_ok = 0;
  logic [31:0] instr = 0, op_a = 0, op_b = 0, cur_psr = 0, saved_psr = 0;
  logic        out_valid, rd_we, psr_we, psr_restore, unpred, not_exec;
  logic [31:0] res, psr_next;
  logic [3:0]  rd_idx;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dp_alu_flags u_dut (.*);

  function automatic logic [31:0] mk(logic [3:0] op, logic i, logic s, logic [3:0] rd, logic b7, logic b4);
    return {4'hE, 2'b00, i, op, s, 4'h3, rd, 4'h0, b7, 2'b00, b4, 4'h0};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(logic [31:0] w, logic [31:0] a, logic [31:0] b, logic co, logic ok,
                     logic [31:0] psr, logic [31:0] sp);
    logic [33:0] s;
    logic add, dec, ex, s_on, rs;
    logic [31:0] v, e_psr;
    logic c, ov;
    instr = w; op_a = a; op_b = b; shift_co = co; cond_ok = ok; cur_psr = psr; saved_psr = sp;
    in_valid = 1;
    add = w[24:21] == 4'b0100;
    dec = w[27:26] == 0 && (add || w[24:21] == 0) && !(!w[25] && w[7] && w[4]);
    ex = dec && ok;
    s = {2'b0, a} + {2'b0, b};
    v = add ? s[31:0] : (a & b);
    c = add ? s[32] : co;
    ov = add ? ((a[31] & b[31] & ~v[31]) | (~a[31] & ~b[31] & v[31])) : psr[28];
    s_on = ex && w[20];
    rs = s_on && w[15:12] == 15;
    e_psr = rs ? sp : (s_on ? {v[31], v == 0, c, ov, psr[27:0]} : psr);
    @(posedge clk); #1;
    in_valid = 0;
    chk("R9 out_valid", out_valid, 1);
    chk(!dec ? (w[25] ? "R1 not_exec" : "R2 not_exec") : "R1 not_exec", not_exec, !dec);
    chk(ok ? "R1 rd_we" : "R3 rd_we", rd_we, ex);
    chk(ok ? "R6 psr_we" : "R3 psr_we", psr_we, s_on);
    chk(add ? "R4 res" : "R5 res", res, ex ? v : 0);
    chk(rs ? "R7 psr_next" : (!w[20] ? "R6 psr_next" : (add ? "R4 psr_next" : "R5 psr_next")), psr_next, e_psr);
    chk("R7 psr_restore", psr_restore, rs);
    chk("R8 unpred", unpred, rs && (psr[4:0] == 5'b10000 || psr[4:0] == 5'b11111));
  endtask

  initial begin
    logic [31:0] cv [5] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};
    repeat (3) @(posedge clk);
    #1;
    chk("R10 out_valid", out_valid, 0);
    chk("R10 res", res, 0);
    chk("R10 psr_next", psr_next, 0);
    chk("R10 rd_we", rd_we, 0);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R9 idle out_valid", out_valid, 0);
    chk("R9 idle rd_we", rd_we, 0);
    for (int op = 0; op < 2; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          for (int k = 0; k < 8; k++)
            run(mk(op ? 4'b0100 : 4'b0000, 1'b0, k[0], 4'd2, 1'b0, 1'b1), cv[i], cv[j], k[1], !k[2],
                {4'b0101, 23'h0, 5'b10011} ^ {3'b0, k[1], 28'h0}, 32'hA000_0011);
    for (int n = 0; n < 400; n++)
      run(mk(n[0] ? 4'b0100 : 4'b0000, n[1], 1'b1, 4'(n % 15), 1'b0, 1'b0), $urandom, $urandom,
          n[2], 1'b1, {4'(n), 23'h0, 5'b10011}, 32'h0);
    run(mk(4'b0100, 0, 1, 4'd15, 0, 0), 32'h5, 32'h6, 0, 1, {4'h0, 23'h0, 5'b10011}, 32'h6000_0010);
    run(mk(4'b0000, 0, 1, 4'd15, 0, 0), 32'h5, 32'h6, 1, 1, {4'hF, 23'h0, 5'b10000}, 32'h9000_001F);
    run(mk(4'b0100, 0, 1, 4'd15, 0, 0), 32'h5, 32'h6, 0, 1, {4'h0, 23'h0, 5'b11111}, 32'h1234_5678);
    run(mk(4'b0100, 0, 0, 4'd15, 0, 0), 32'h5, 32'h6, 0, 1, {4'h0, 23'h0, 5'b10000}, 32'h1234_5678);
    run(mk(4'b0100, 0, 1, 4'd15, 0, 0), 32'h5, 32'h6, 0, 0, {4'h0, 23'h0, 5'b10000}, 32'h1234_5678);
    run(mk(4'b0100, 0, 1, 4'd1, 1, 1), 32'h5, 32'h6, 0, 1, 32'h13, 0);
    run(mk(4'b0000, 0, 1, 4'd1, 1, 1), 32'h5, 32'h6, 0, 1, 32'h13, 0);
    run(mk(4'b0100, 1, 1, 4'd1, 1, 1), 32'h5, 32'h6, 0, 1, 32'h13, 0);
    run(mk(4'b0100, 0, 1, 4'd1, 1, 0), 32'h5, 32'h6, 0, 1, 32'h13, 0);
    run(mk(4'b0010, 0, 1, 4'd1, 0, 0), 32'h5, 32'h6, 0, 1, 32'h13, 0);
    run(mk(4'b1100, 0, 1, 4'd1, 0, 0), 32'h5, 32'h6, 0, 1, 32'h13, 0);
    run(mk(4'b0100, 0, 1, 4'd1, 0, 0) | 32'h0400_0000, 32'h5, 32'h6, 0, 1, 32'h13, 0);
    @(posedge clk); #1;
    chk("R9 idle after", {31'b0, out_valid | rd_we | psr_we | not_exec | unpred}, 0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin checks++; fails++; $display("FAIL watchdog actual=timeout expected=done"); end
    #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule